// File: doc/BRIEF.md
# Chained Watchdog Counter Bank

The block holds a small bank of 64-bit down-counters behind a 32-bit register port. Each counter has a control word, a reload value and a live count. It can run as a one-shot timer or wait for a hardware trigger. A triggered counter restarts from its reload value every time the counter numbered just below it reaches end of count.

A select register marks which counters act as the system watchdog. When a marked counter expires, the block raises a one-cycle reset request. Software keeps the watchdog alive without ever stopping it. It points the watchdog counter's trigger at a helper counter loaded with zero, then turns the helper's enable off and on. Each time it does so, the helper produces an end-of-count at once, and that event reloads the watchdog.

Reading a 64-bit live count takes two 32-bit reads. Reading the low word also captures the upper half, so the pair of reads always returns one consistent value.

Top module: `chained_wdt_bank`

## Requirements
- R1: After reset every control word, count word and the select register read as zero, and `wdog_rst_o` is low.
- R2: Counter n's control word sits at offset n*0x10, its low count word at n*0x10+0x4 and its high count word at n*0x10+0x8. The select register sits at 0x40. Unmapped offsets read as zero. Writing the count words sets the reload value, and reading them returns the live count.
- R3: Control word layout: bit 0 is enable, bit 1 is the read-only active flag (writes to it are ignored), bits 3:2 are the mode, bits 7:4 the trigger source and bits 15:8 the prescaler. Bits above 15 read as zero.
- R4: An active counter decrements once every P clock cycles, where P is the prescaler field. A field value of 0 or 1 decrements every cycle.
- R5: In one-shot mode (mode 00), writing enable from 0 to 1 loads the live count from the reload value and sets active. When the live count reaches zero, the counter emits one end-of-count cycle and clears active.
- R6: A one-shot counter with reload value 0 emits its end-of-count in the cycle right after the enabling write. Each further off-then-on toggle of its enable produces a fresh end-of-count.
- R7: In trigger mode (mode 11), enable alone does not start counting. With source code 0x5, each end-of-count of counter n-1 reloads counter n and sets it active, even while it is already counting. Counter 0 has no such source.
- R8: A read of a counter's low word captures its upper 32 live bits. A later read of its high word returns the captured value, even if the live count has changed in between.
- R9: When a counter whose select bit is set reaches end of count, `wdog_rst_o` goes high for exactly one cycle, one cycle after the end-of-count. With the select register at zero, no reset request is ever raised.
- R10: Writing enable to 0 clears active at once and freezes the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered, valid the cycle after the read strobe |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
Each register access takes effect on one clock edge W, and read data is sampled on the falling edge that follows W. A one-shot watchdog with reload R and prescaler P raises its reset request P*R+1 cycles after the enabling write. A chained watchdog pinged through a zero-loaded helper raises it P*R+2 cycles after the helper's enabling write. The bench counts falling edges from W and compares the count with these figures exactly. A stale or early expiry therefore shows up as a wrong count, not as a missed pulse.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_RSV1    = 2'b01,
        MODE_RSV2    = 2'b10,
        MODE_HWTRIG  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [7:0] psc;
        logic [3:0] src;
        mode_e      mode;
        logic       act;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int EN_BIT   = 0;
    localparam int MODE_LSB = 2;
    localparam int SRC_LSB  = 4;
    localparam int PSC_LSB  = 8;

    localparam logic [3:0] SRC_PREV_EOC = 4'h5;

    typedef enum logic [1:0] {
        WORD_CTRL,
        WORD_LOW,
        WORD_HIGH,
        WORD_NONE
    } word_e;

    function automatic word_e word_of(input logic [3:0] off);
        case (off)
            4'h0:    return WORD_CTRL;
            4'h4:    return WORD_LOW;
            4'h8:    return WORD_HIGH;
            default: return WORD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wcb_prescale.sv
module wcb_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] last;

    always_comb begin
        last   = (psc_i < PSC_W'(2)) ? '0 : psc_i - PSC_W'(1);
        tick_o = run_i && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PSC_W'(1);
        end
    end
endmodule

// File: rtl/wcb_counter.sv
module wcb_counter
    import wcb_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we_i,
    input  logic              lo_we_i,
    input  logic              hi_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              trig_in_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  live_o,
    output logic              eoc_o,
    output logic              active_o,
    output logic              enable_o,
    output logic              fire_o
);
    logic             en_q;
    mode_e            mode_q;
    logic [3:0]       src_q;
    logic [7:0]       psc_q;
    logic             active_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] live_q;

    logic  wr_en;
    mode_e wr_mode;
    logic  start_os;
    logic  hw_fire;
    logic  run;
    logic  tick;

    always_comb begin
        wr_en    = wdata_i[EN_BIT];
        wr_mode  = mode_e'(wdata_i[MODE_LSB +: 2]);
        start_os = ctrl_we_i && wr_en && !en_q && (wr_mode != MODE_HWTRIG);
        hw_fire  = en_q && (mode_q == MODE_HWTRIG) && (src_q == SRC_PREV_EOC) && trig_in_i;
        eoc_o    = en_q && active_q && (live_q == '0);
        run      = en_q && active_q && (live_q != '0);
    end

    wcb_prescale #(.PSC_W(8)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_os || hw_fire),
        .run_i   (run),
        .psc_i   (psc_q),
        .tick_o  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            mode_q   <= MODE_ONESHOT;
            src_q    <= '0;
            psc_q    <= '0;
            active_q <= 1'b0;
            reload_q <= '0;
            live_q   <= '0;
        end else begin
            if (ctrl_we_i) begin
                en_q   <= wr_en;
                mode_q <= wr_mode;
                src_q  <= wdata_i[SRC_LSB +: 4];
                psc_q  <= wdata_i[PSC_LSB +: 8];
            end
            if (lo_we_i) reload_q[DATA_W-1:0]     <= wdata_i;
            if (hi_we_i) reload_q[CNT_W-1:DATA_W] <= wdata_i;

            if (ctrl_we_i && !wr_en) begin
                active_q <= 1'b0;
            end else if (start_os || hw_fire) begin
                live_q   <= reload_q;
                active_q <= 1'b1;
            end else if (eoc_o) begin
                active_q <= 1'b0;
            end else if (tick) begin
                live_q <= live_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        ctrl_o      = '{psc: psc_q, src: src_q, mode: mode_q, act: active_q, en: en_q};
        live_o      = live_q;
        active_o    = active_q;
        enable_o    = en_q;
        fire_o      = hw_fire;
    end
endmodule

// File: rtl/wcb_regport.sv
module wcb_regport
    import wcb_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SEL_ADDR = 'h40,
    localparam int CNT_W   = 2 * DATA_W,
    localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int BLK_W   = ADDR_W - 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_i,
    input  logic                           rd_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [NUM_CNT-1:0][CTRL_W-1:0] ctrl_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  live_i,
    output logic [NUM_CNT-1:0]             ctrl_we_o,
    output logic [NUM_CNT-1:0]             lo_we_o,
    output logic [NUM_CNT-1:0]             hi_we_o,
    output logic [NUM_CNT-1:0]             sel_o,
    output logic [DATA_W-1:0]              rdata_o
);
    logic [BLK_W-1:0]                 blk;
    logic [IDX_W-1:0]                 idx;
    logic                             in_bank;
    logic                             sel_hit;
    word_e                            kind;
    logic [NUM_CNT-1:0]               sel_q;
    logic [NUM_CNT-1:0][DATA_W-1:0]   hold_q;

    always_comb begin
        blk     = addr_i[ADDR_W-1:4];
        idx     = blk[IDX_W-1:0];
        in_bank = (blk < BLK_W'(NUM_CNT));
        sel_hit = (addr_i == ADDR_W'(SEL_ADDR));
        kind    = word_of(addr_i[3:0]);
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_strobe
        logic hit;
        assign hit          = wr_i && in_bank && (idx == IDX_W'(i));
        assign ctrl_we_o[i] = hit && (kind == WORD_CTRL);
        assign lo_we_o[i]   = hit && (kind == WORD_LOW);
        assign hi_we_o[i]   = hit && (kind == WORD_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            hold_q  <= '0;
            rdata_o <= '0;
        end else begin
            if (wr_i && sel_hit) sel_q <= wdata_i[NUM_CNT-1:0];
            if (rd_i) begin
                rdata_o <= '0;
                if (sel_hit) begin
                    rdata_o <= DATA_W'(sel_q);
                end else if (in_bank) begin
                    case (kind)
                        WORD_CTRL: rdata_o <= DATA_W'(ctrl_i[idx]);
                        WORD_LOW: begin
                            rdata_o     <= live_i[idx][DATA_W-1:0];
                            hold_q[idx] <= live_i[idx][CNT_W-1:DATA_W];
                        end
                        WORD_HIGH: rdata_o <= hold_q[idx];
                        default:   rdata_o <= '0;
                    endcase
                end
            end
        end
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/chained_wdt_bank.sv
module chained_wdt_bank
    import wcb_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SEL_ADDR = 'h40,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              wdog_rst_o
);
    logic [NUM_CNT-1:0]             ctrl_we;
    logic [NUM_CNT-1:0]             lo_we;
    logic [NUM_CNT-1:0]             hi_we;
    logic [NUM_CNT-1:0]             sel_q;
    logic [NUM_CNT-1:0]             eoc;
    logic [NUM_CNT-1:0]             active;
    logic [NUM_CNT-1:0]             enable;
    logic [NUM_CNT-1:0]             fire;
    logic [NUM_CNT-1:0]             trig_src;
    logic [NUM_CNT-1:0][CTRL_W-1:0] ctrl_rd;
    logic [NUM_CNT-1:0][CNT_W-1:0]  live;

    wcb_regport #(
        .NUM_CNT  (NUM_CNT),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_ADDR (SEL_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .ctrl_i    (ctrl_rd),
        .live_i    (live),
        .ctrl_we_o (ctrl_we),
        .lo_we_o   (lo_we),
        .hi_we_o   (hi_we),
        .sel_o     (sel_q),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i == 0) begin : g_first
            assign trig_src[i] = 1'b0;
        end else begin : g_chain
            assign trig_src[i] = eoc[i-1];
        end

        ctrl_t ctrl_w;
        assign ctrl_rd[i] = ctrl_w;

        wcb_counter #(.DATA_W(DATA_W)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .ctrl_we_i (ctrl_we[i]),
            .lo_we_i   (lo_we[i]),
            .hi_we_i   (hi_we[i]),
            .wdata_i   (reg_wdata_i),
            .trig_in_i (trig_src[i]),
            .ctrl_o    (ctrl_w),
            .live_o    (live[i]),
            .eoc_o     (eoc[i]),
            .active_o  (active[i]),
            .enable_o  (enable[i]),
            .fire_o    (fire[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdog_rst_o <= 1'b0;
        end else begin
            wdog_rst_o <= |(sel_q & eoc);
        end
    end
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
    parameter int NUM_CNT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wdog_rst_i,
    input logic [NUM_CNT-1:0] sel_i,
    input logic [NUM_CNT-1:0] eoc_i,
    input logic [NUM_CNT-1:0] active_i,
    input logic [NUM_CNT-1:0] enable_i,
    input logic [NUM_CNT-1:0] fire_i
);
    AST_RST_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_i |-> $past(|(sel_i & eoc_i))); // R9
    AST_NO_CAUSE_NO_RST: assert property (@(posedge clk) disable iff (rst)
        ((sel_i & eoc_i) == '0) |=> !wdog_rst_i); // R9

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        AST_EOC_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
            (eoc_i[i] && !fire_i[i]) |=> !active_i[i]); // R5
        AST_OFF_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
            !enable_i[i] |-> !active_i[i]); // R10
        AST_TRIGGER_ARMS: assert property (@(posedge clk) disable iff (rst)
            fire_i[i] |=> (active_i[i] || !enable_i[i])); // R7
        AST_ACTIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
            $rose(active_i[i]) |-> enable_i[i]); // R7
    end
endmodule

bind chained_wdt_bank wcb_checker #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wdog_rst_i (wdog_rst_o),
    .sel_i      (sel_q),
    .eoc_i      (eoc),
    .active_i   (active),
    .enable_i   (enable),
    .fire_i     (fire)
);

// File: tb/chained_wdt_bank_tb_top.sv
module chained_wdt_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdog_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    chained_wdt_bank dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .wdog_rst_o  (wdog_rst)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic wait_rst(input int limit, output int n);
        n = 0;
        while (!wdog_rst && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle_no_rst(input int cycles, output int seen);
        seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (wdog_rst) seen++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            for (int w = 0; w < 3; w++) begin
                do_rd(8'(c * 16 + w * 4), d);
                check($sformatf("R1 reg c%0d w%0d", c, w), d, 0);
            end
        end
        do_rd(8'h40, d);
        check("R1 select", d, 0);
        check("R1 wdog_rst", wdog_rst, 0);
    endtask

    task automatic t_ctrl_fields;
        logic [31:0] d;
        do_wr(8'h30, 32'h0000_AB5E);
        do_rd(8'h30, d);
        check("R3 active bit read-only", d, 32'hAB5C);
        do_wr(8'h30, 32'h1234_AB5C);
        do_rd(8'h30, d);
        check("R3 upper bits zero", d, 32'hAB5C);
        do_wr(8'h30, 32'h0000_AB5D);
        do_rd(8'h30, d);
        check("R7 enable alone idle", d, 32'hAB5D);
        do_wr(8'h30, 32'h0);
    endtask

    task automatic t_addr_map;
        logic [31:0] d;
        do_wr(8'h34, 32'h0000_5678);
        do_wr(8'h38, 32'h0000_1234);
        do_wr(8'h30, 32'h0000_FF01);
        do_rd(8'h34, d);
        check("R2 low live", d, 32'h5678);
        do_rd(8'h38, d);
        check("R2 high live", d, 32'h1234);
        do_rd(8'h3C, d);
        check("R2 unmapped", d, 0);
        do_wr(8'h40, 32'h0000_0009);
        do_rd(8'h40, d);
        check("R2 select readback", d, 32'h9);
        do_wr(8'h40, 32'h0);
        do_wr(8'h30, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        int n;
        do_wr(8'h04, 32'd5);
        do_wr(8'h08, 32'd0);
        do_wr(8'h40, 32'h1);
        do_wr(8'h00, 32'h0000_0301);
        wait_rst(200, n);
        check("R4 R5 one-shot expiry cycles", n, 16);
        @(negedge clk);
        check("R9 pulse one cycle", wdog_rst, 0);
        do_rd(8'h00, d);
        check("R5 active cleared", d, 32'h0301);
        do_wr(8'h00, 32'h0);
        do_wr(8'h04, 32'd7);
        do_wr(8'h00, 32'h0000_0001);
        wait_rst(200, n);
        check("R4 prescale zero", n, 8);
        do_wr(8'h00, 32'h0);
        do_wr(8'h40, 32'h0);
    endtask

    task automatic t_latch;
        logic [31:0] d;
        do_wr(8'h24, 32'd3);
        do_wr(8'h28, 32'd1);
        do_wr(8'h20, 32'h0000_0001);
        do_rd(8'h24, d);
        check("R8 low word", d, 32'd3);
        repeat (10) @(negedge clk);
        do_rd(8'h28, d);
        check("R8 high held", d, 32'd1);
        do_rd(8'h24, d);
        do_rd(8'h28, d);
        check("R8 high after new low", d, 32'd0);
        do_wr(8'h20, 32'h0);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        int n;
        int seen;
        do_wr(8'h40, 32'h2);
        do_wr(8'h14, 32'd20);
        do_wr(8'h18, 32'd0);
        do_wr(8'h04, 32'd0);
        do_wr(8'h10, 32'h0000_025D);
        do_wr(8'h00, 32'h0000_0200);
        do_wr(8'h00, 32'h0000_0201);
        wait_rst(200, n);
        check("R6 R7 R9 chained expiry cycles", n, 42);
        @(negedge clk);
        check("R9 chained pulse one cycle", wdog_rst, 0);
        do_wr(8'h00, 32'h0000_0200);
        do_wr(8'h00, 32'h0000_0201);
        idle_no_rst(30, seen);
        check("R6 no expiry before ping", seen, 0);
        do_rd(8'h10, d);
        check("R7 watchdog still active", d, 32'h025F);
        do_wr(8'h00, 32'h0000_0200);
        do_wr(8'h00, 32'h0000_0201);
        wait_rst(200, n);
        check("R6 R7 re-ping restarts count", n, 42);
        @(negedge clk);
    endtask

    task automatic t_sel_off;
        logic [31:0] d;
        int n;
        do_wr(8'h40, 32'h0);
        do_wr(8'h00, 32'h0000_0200);
        do_wr(8'h00, 32'h0000_0201);
        wait_rst(80, n);
        check("R9 select zero no reset", n, 80);
        do_rd(8'h10, d);
        check("R7 expired clears active", d, 32'h025D);
    endtask

    task automatic t_disable;
        logic [31:0] d1;
        logic [31:0] d2;
        int n;
        do_wr(8'h40, 32'h2);
        do_wr(8'h00, 32'h0000_0200);
        do_wr(8'h00, 32'h0000_0201);
        repeat (5) @(negedge clk);
        do_wr(8'h10, 32'h0000_025C);
        wait_rst(80, n);
        check("R10 disabled no reset", n, 80);
        do_rd(8'h10, d1);
        check("R10 active cleared", d1, 32'h025C);
        do_rd(8'h14, d1);
        repeat (5) @(negedge clk);
        do_rd(8'h14, d2);
        check("R10 count frozen value", d1, 32'd18);
        check("R10 count frozen stable", d2, d1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_fields();
        t_addr_map();
        t_oneshot();
        t_latch();
        t_chain();
        t_sel_off();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule